// File: doc/BRIEF.md
# Looping Instruction Sequencer

This block steps through a 32-word instruction store for a small programmable I/O engine. It holds a 5-bit program counter that drives the store's read address. In each active cycle it either moves to the next word or stays on the current one while a stall runs. Two absolute addresses, a loop-end and a loop-start, form a hardware loop. After the word at the loop-end address finishes, the next fetch comes from the loop-start address. This costs no extra cycle, so no jump word is needed. Words placed before the loop-start address run only once. A typical use is a one-time word that sets the pin direction, followed by the loop body.

Each word can carry a stall count. After the word executes, the sequencer holds on it for that many extra cycles. This lets a slower waveform keep equal high and low times. Only one operation is decoded here: a write to the pin-value register or to the pin-direction register. A restart input loads the counter from a start-address input and drops any stall in progress. The enable input freezes the engine in place without losing its position.

The sequencer is a two-state machine. In EXEC it executes the word at the counter. In STALL it counts down the extra cycles. The transitions are:
- EXEC→EXEC: a word with zero stall executes, and the counter advances.
- EXEC→STALL: a word with a nonzero stall executes, and the counter holds.
- STALL→STALL: the countdown is still running.
- STALL→EXEC: the last stall cycle ends, and the counter advances.
- any→EXEC: restart.

Top module: `pcs_seq_top`

## Requirements
- R1: While rst_n is low, and after it is released, the counter is 0, pins_out is 0 and dirs_out is 0, and the machine is in EXEC.
- R2: The read address imem_addr always equals the counter. When the executing word's address is not the loop-end address, the counter advances by one modulo 32, so 31 is followed by 0.
- R3: When the word at loop_end finishes, the counter becomes loop_start on the same edge, with no extra cycle. Both addresses are absolute. A two-word loop of "pins high" and "pins low" therefore toggles pins_out on every clock.
- R4: Word layout: bits [15:13] are the opcode, and 3'b111 is the write operation. Bits [12:8] are the stall count. Bits [7:5] are the target: 3'b000 selects pins_out and 3'b100 selects dirs_out. Bits [4:0] are the value. The selected register takes the value on the edge that ends the word's EXEC cycle.
- R5: A word whose opcode is not 3'b111, or a write word with any other target code, leaves pins_out and dirs_out unchanged. The counter still advances.
- R6: A word with stall count d occupies d+1 enabled cycles before the counter moves on, and pins_out and dirs_out stay stable during the stall.
- R7: A restart pulse loads the counter with start_addr on the next edge, even while enable is low. It cancels any pending stall, so the word at start_addr then executes with its own stall count only.
- R8: While enable is low, the counter, the stall progress, pins_out and dirs_out all hold. Execution resumes from the same point when enable returns.
- R9: Words before loop_start execute only once. The counter never returns below loop_start unless a restart occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low freezes the engine |
| restart | input | 1 | Loads the counter from start_addr and clears the stall |
| start_addr | input | 5 | Address loaded on restart |
| loop_end | input | 5 | Absolute address of the last word in the loop |
| loop_start | input | 5 | Absolute address fetched after loop_end |
| imem_addr | output | 5 | Instruction store read address (the counter) |
| imem_data | input | 16 | Word read combinationally at imem_addr |
| pins_out | output | 5 | Pin value register |
| dirs_out | output | 5 | Pin direction register |

## Verification
Every result is registered once, so it is due exactly one rising edge after the cycle that causes it. A word executed in one cycle shows its new pin value, and the following address, after the next rising edge. A restart shows start_addr after one edge. A stall of d keeps the address unchanged for d further edges. The bench changes inputs and samples outputs only on falling edges. Each expected state is therefore compared half a cycle after the edge that should produce it and half a cycle before the next one. The vector walk checks one state per edge, so an extra or a missing cycle at the loop point shows up immediately.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int PC_W    = 5;
    localparam int INSTR_W = 16;
    localparam int OP_W    = 3;
    localparam int DLY_W   = 5;
    localparam int DST_W   = 3;
    localparam int VAL_W   = 5;

    localparam int VAL_LSB = 0;
    localparam int DST_LSB = VAL_LSB + VAL_W;
    localparam int DLY_LSB = DST_LSB + DST_W;
    localparam int OP_LSB  = DLY_LSB + DLY_W;

    localparam logic [OP_W-1:0]  OP_WRITE = 3'b111;
    localparam logic [DST_W-1:0] DST_PINS = 3'b000;
    localparam logic [DST_W-1:0] DST_DIRS = 3'b100;

    typedef enum logic {
        ST_EXEC  = 1'b0,
        ST_STALL = 1'b1
    } seq_state_t;
endpackage

// File: rtl/pcs_next_addr.sv
module pcs_next_addr #(
    parameter int PC_W = 5
) (
    input  logic [PC_W-1:0] cur_addr,
    input  logic [PC_W-1:0] loop_end,
    input  logic [PC_W-1:0] loop_start,
    output logic [PC_W-1:0] nxt_addr
);
    always_comb begin
        if (cur_addr == loop_end) begin
            nxt_addr = loop_start;
        end else begin
            nxt_addr = cur_addr + PC_W'(1);
        end
    end
endmodule

// File: rtl/pcs_stall_ctr.sv
module pcs_stall_ctr #(
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - DLY_W'(1);
        end
    end

    assign last = (cnt_q == DLY_W'(1));
endmodule

// File: rtl/pcs_pin_unit.sv
module pcs_pin_unit
    import pcs_pkg::*;
#(
    parameter int PIN_W = VAL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec,
    input  logic [OP_W-1:0]  op,
    input  logic [DST_W-1:0] dst,
    input  logic [PIN_W-1:0] val,
    output logic [PIN_W-1:0] pins_q,
    output logic [PIN_W-1:0] dirs_q
);
    logic hit;
    assign hit = exec && (op == OP_WRITE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= '0;
            dirs_q <= '0;
        end else if (hit) begin
            if (dst == DST_PINS) pins_q <= val;
            if (dst == DST_DIRS) dirs_q <= val;
        end
    end
endmodule

// File: rtl/pcs_seq_top.sv
module pcs_seq_top
    import pcs_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int IW = INSTR_W,
    parameter int PW = VAL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          restart,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] loop_end,
    input  logic [AW-1:0] loop_start,
    output logic [AW-1:0] imem_addr,
    input  logic [IW-1:0] imem_data,
    output logic [PW-1:0] pins_out,
    output logic [PW-1:0] dirs_out
);
    seq_state_t state_q, state_d;
    logic [AW-1:0] pc_q, pc_d, pc_nxt;

    logic [OP_W-1:0]  f_op;
    logic [DLY_W-1:0] f_dly;
    logic [DST_W-1:0] f_dst;
    logic [PW-1:0]    f_val;

    logic exec_go, dly_load, dly_dec, advance, dly_last, stalling;

    assign f_op  = imem_data[OP_LSB  +: OP_W];
    assign f_dly = imem_data[DLY_LSB +: DLY_W];
    assign f_dst = imem_data[DST_LSB +: DST_W];
    assign f_val = imem_data[VAL_LSB +: PW];

    pcs_next_addr #(.PC_W(AW)) u_next (
        .cur_addr   (pc_q),
        .loop_end   (loop_end),
        .loop_start (loop_start),
        .nxt_addr   (pc_nxt)
    );

    pcs_stall_ctr #(.DLY_W(DLY_W)) u_stall (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart),
        .load     (dly_load),
        .load_val (f_dly),
        .dec      (dly_dec),
        .last     (dly_last)
    );

    pcs_pin_unit #(.PIN_W(PW)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .exec   (exec_go),
        .op     (f_op),
        .dst    (f_dst),
        .val    (f_val),
        .pins_q (pins_out),
        .dirs_q (dirs_out)
    );

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EXEC;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_EXEC;
        end else if (enable) begin
            unique case (state_q)
                ST_EXEC:  if (f_dly != '0) state_d = ST_STALL;
                ST_STALL: if (dly_last)    state_d = ST_EXEC;
            endcase
        end
    end

    // output process: strobes for datapath units
    always_comb begin
        exec_go  = 1'b0;
        dly_load = 1'b0;
        dly_dec  = 1'b0;
        advance  = 1'b0;
        if (enable && !restart) begin
            unique case (state_q)
                ST_EXEC: begin
                    exec_go  = 1'b1;
                    dly_load = (f_dly != '0);
                    advance  = (f_dly == '0);
                end
                ST_STALL: begin
                    dly_dec = 1'b1;
                    advance = dly_last;
                end
            endcase
        end
    end

    always_comb begin
        if (restart)      pc_d = start_addr;
        else if (advance) pc_d = pc_nxt;
        else              pc_d = pc_q;
    end

    assign stalling  = (state_q == ST_STALL);
    assign imem_addr = pc_q;
endmodule

// File: rtl/pcs_seq_chk.sv
module pcs_seq_chk #(
    parameter int AW = 5,
    parameter int PW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          restart,
    input logic [AW-1:0] start_addr,
    input logic [AW-1:0] loop_end,
    input logic [AW-1:0] loop_start,
    input logic [AW-1:0] imem_addr,
    input logic [2:0]    op,
    input logic [4:0]    dly,
    input logic [PW-1:0] pins_out,
    input logic [PW-1:0] dirs_out,
    input logic          stalling
);
    logic step_now;
    assign step_now = enable && !restart && !stalling && (dly == 5'd0);

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_now && imem_addr != loop_end) |=> (imem_addr == $past(imem_addr) + AW'(1)));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_now && imem_addr == loop_end) |=> (imem_addr == $past(loop_start)));

    a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !restart && !stalling && op != 3'b111) |=> ($stable(pins_out) && $stable(dirs_out)));

    a_r6_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !restart && stalling) |=> ($stable(pins_out) && $stable(dirs_out)));

    a_r7_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (imem_addr == $past(start_addr)));

    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !restart) |=> ($stable(imem_addr) && $stable(pins_out) && $stable(dirs_out)));
endmodule

bind pcs_seq_top pcs_seq_chk #(.AW(AW), .PW(PW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .restart    (restart),
    .start_addr (start_addr),
    .loop_end   (loop_end),
    .loop_start (loop_start),
    .imem_addr  (imem_addr),
    .op         (imem_data[15:13]),
    .dly        (imem_data[12:8]),
    .pins_out   (pins_out),
    .dirs_out   (dirs_out),
    .stalling   (stalling)
);

// File: tb/pcs_seq_top_tb_top.sv
`timescale 1ns/1ps
module pcs_seq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, enable, restart;
    logic [4:0]  start_addr, loop_end, loop_start, imem_addr;
    logic [15:0] imem_data;
    logic [4:0]  pins_out, dirs_out;
    logic [15:0] mem [32];

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    assign imem_data = mem[imem_addr];

    pcs_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
        .start_addr(start_addr), .loop_end(loop_end), .loop_start(loop_start),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .pins_out(pins_out), .dirs_out(dirs_out)
    );

    // write word: op 111, stall, target, value
    function automatic logic [15:0] wr(input logic [2:0] dst, input logic [4:0] v, input logic [4:0] d);
        return {3'b111, d, dst, v};
    endfunction

    // {pc, pin bit, dir bit} after each edge of the fast loop (R3, R4, R9)
    localparam logic [6:0] VEC [8] = '{
        {5'd0, 1'b0, 1'b0}, {5'd1, 1'b0, 1'b1}, {5'd2, 1'b1, 1'b1}, {5'd1, 1'b0, 1'b1},
        {5'd2, 1'b1, 1'b1}, {5'd1, 1'b0, 1'b1}, {5'd2, 1'b1, 1'b1}, {5'd1, 1'b0, 1'b1}
    };

    task automatic expect_st(input logic [4:0] pc, input logic pin, input logic dir, input string tag);
        total++;
        if (imem_addr !== pc || pins_out !== {4'b0, pin} || dirs_out !== {4'b0, dir}) begin
            bad++;
            $display("FAIL %s: got pc=%0d pins=%0d dirs=%0d, expected pc=%0d pins=%0d dirs=%0d",
                     tag, imem_addr, pins_out, dirs_out, pc, pin, dir);
        end
    endtask

    task automatic edge_n();
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 16'h0000;
        mem[0]  = wr(3'b100, 5'd1, 5'd0);   // dirs <- 1
        mem[1]  = wr(3'b000, 5'd1, 5'd0);   // pins <- 1
        mem[2]  = wr(3'b000, 5'd0, 5'd0);   // pins <- 0
        mem[3]  = 16'h0001;                 // other opcode, value 1
        mem[4]  = wr(3'b010, 5'd1, 5'd0);   // unknown target
        mem[10] = wr(3'b100, 5'd1, 5'd0);
        mem[11] = wr(3'b000, 5'd1, 5'd1);   // pins <- 1, stall 1
        mem[12] = wr(3'b000, 5'd0, 5'd1);   // pins <- 0, stall 1

        rst_n = 1'b0; enable = 1'b0; restart = 1'b0;
        start_addr = 5'd0; loop_end = 5'd2; loop_start = 5'd1;
        repeat (3) edge_n();
        expect_st(5'd0, 1'b0, 1'b0, "R1 reset state");
        enable = 1'b1;
        rst_n  = 1'b1;

        // fast loop: one state per edge
        for (int i = 0; i < 8; i++) begin
            expect_st(VEC[i][6:2], VEC[i][1], VEC[i][0], $sformatf("R3 loop vector %0d", i));
            edge_n();
        end
        expect_st(5'd2, 1'b1, 1'b1, "R9 loop never revisits 0");

        // freeze
        enable = 1'b0;
        for (int i = 0; i < 3; i++) begin
            edge_n();
            expect_st(5'd2, 1'b1, 1'b1, "R8 hold while disabled");
        end
        enable = 1'b1;
        edge_n();
        expect_st(5'd1, 1'b0, 1'b1, "R8 resume after enable");

        // relocated slow loop at 10..12
        loop_end = 5'd12; loop_start = 5'd11; start_addr = 5'd10; restart = 1'b1;
        edge_n();
        restart = 1'b0;
        expect_st(5'd10, 1'b0, 1'b1, "R7 restart loads start");
        edge_n(); expect_st(5'd11, 1'b0, 1'b1, "R2 advance from 10");
        edge_n(); expect_st(5'd11, 1'b1, 1'b1, "R6 stall holds pc");
        edge_n(); expect_st(5'd12, 1'b1, 1'b1, "R6 pins stable in stall");
        edge_n(); expect_st(5'd12, 1'b0, 1'b1, "R6 second word stall");
        edge_n(); expect_st(5'd11, 1'b0, 1'b1, "R3 absolute wrap");
        edge_n(); expect_st(5'd11, 1'b1, 1'b1, "R6 stall entered");
        enable = 1'b0;
        edge_n(); expect_st(5'd11, 1'b1, 1'b1, "R8 hold in stall");
        edge_n(); expect_st(5'd11, 1'b1, 1'b1, "R8 hold in stall 2");
        enable = 1'b1;
        edge_n(); expect_st(5'd12, 1'b1, 1'b1, "R8 stall resumes");
        edge_n(); expect_st(5'd12, 1'b0, 1'b1, "R6 in stall on 12");

        // restart during stall cancels it
        start_addr = 5'd2; restart = 1'b1;
        edge_n();
        restart = 1'b0;
        expect_st(5'd2, 1'b0, 1'b1, "R7 restart in stall");
        edge_n(); expect_st(5'd3, 1'b0, 1'b1, "R7 stall cancelled");
        edge_n(); expect_st(5'd4, 1'b0, 1'b1, "R5 other opcode ignored");
        edge_n(); expect_st(5'd5, 1'b0, 1'b1, "R5 unknown target ignored");

        // restart while disabled, then modulo-32 step
        enable = 1'b0; start_addr = 5'd30; restart = 1'b1;
        edge_n();
        restart = 1'b0;
        expect_st(5'd30, 1'b0, 1'b1, "R7 restart while disabled");
        enable = 1'b1;
        edge_n(); expect_st(5'd31, 1'b0, 1'b1, "R2 step to 31");
        edge_n(); expect_st(5'd0, 1'b0, 1'b1, "R2 modulo 32 rollover");
        edge_n(); expect_st(5'd1, 1'b0, 1'b1, "R4 dirs write repeats");

        // reset mid-run
        rst_n = 1'b0;
        edge_n(); expect_st(5'd0, 1'b0, 1'b0, "R1 reset mid-run");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule